// File: doc/BRIEF.md
# Reorder Buffer for In-Order Retirement

This block keeps track of instructions that have been issued but not yet retired, so that their results reach architectural state strictly in program order even when execution finishes out of order. Issue logic asks for a slot on the allocate port and receives the slot number as the instruction's destination tag. When an execution unit broadcasts a result on the result bus, the writeback port stores the value in the entry named by the tag and marks it complete. Every cycle the oldest entry is retired if it is complete: its kind, destination and value are presented on the commit port for the register file or the store path.

Rollback is built in. A branch entry carries a mispredict flag delivered with its writeback. When that branch retires, the block raises its flush output and discards every younger entry. An external flush input, used for exceptions, empties the buffer in the same way and suppresses retirement in that cycle. Later instructions can read a complete but not yet retired result by presenting its tag on the lookup port.

Top module: `rob_top`

## Requirements
- R1: After reset the buffer is empty: occupancy is 0, allocReady is 1, allocTag is 0, commitValid and flushOut are 0.
- R2: A request on allocValid while allocReady is high claims the slot shown on allocTag; the tag then advances by one, wrapping from DEPTH-1 to 0.
- R3: With DEPTH entries occupied allocReady is low, a request on allocValid changes nothing, and occupancy never exceeds DEPTH.
- R4: A writeback (wbValid, wbTag, wbValue) to an occupied slot marks it complete; from the next cycle lookupReady is high and lookupValue equals wbValue when lookupTag names that slot, and lookupReady is low for a slot that is free or not yet complete.
- R5: commitValid is high only when the oldest occupied entry is complete and flushIn is low; a complete younger entry never retires ahead of it.
- R6: In a retiring cycle commitKind, commitDest and commitValue carry the oldest entry's kind, destination and written value; the slot is freed and occupancy falls by one. Kind encoding: 0 register result, 1 store, 2 branch.
- R7: An allocation and a retirement in the same cycle leave occupancy unchanged.
- R8: When a branch (kind 2) whose writeback carried wbMispredict=1 retires, flushOut is high in that cycle; in the next cycle occupancy is 0 and allocTag is 0, and an allocation requested in the flush cycle is dropped.
- R9: flushIn forces flushOut high and commitValid low in its cycle; in the next cycle occupancy is 0 and allocTag is 0.
- R10: A writeback to a free slot is ignored: that slot shows lookupReady low, and once it is allocated it stays incomplete until a writeback of its own.
- R11: A branch that retires with its mispredict flag clear does not raise flushOut and the buffer keeps its younger entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Request a slot for a newly issued instruction |
| allocKind | input | 2 | Kind of the new instruction (0 register, 1 store, 2 branch) |
| allocDest | input | REG_W (5) | Destination register of the new instruction |
| allocReady | output | 1 | A slot is free |
| allocTag | output | TAG_W (3) | Slot number given to the new instruction |
| wbValid | input | 1 | Result bus carries a result |
| wbTag | input | TAG_W (3) | Slot the result belongs to |
| wbValue | input | DATA_W (32) | Result value |
| wbMispredict | input | 1 | Branch result was mispredicted |
| flushIn | input | 1 | Discard all entries (exception) |
| lookupTag | input | TAG_W (3) | Slot to read as an operand source |
| lookupReady | output | 1 | Looked-up slot holds a complete result |
| lookupValue | output | DATA_W (32) | Result of the looked-up slot |
| commitValid | output | 1 | Oldest entry retires this cycle |
| commitKind | output | 2 | Kind of the retiring entry |
| commitDest | output | REG_W (5) | Destination of the retiring entry |
| commitValue | output | DATA_W (32) | Value of the retiring entry |
| flushOut | output | 1 | Buffer is being emptied this cycle |
| occupancy | output | CNT_W (4) | Number of occupied slots |

## Verification
The commit, flush, ready and lookup outputs are combinational on the stored state and the current flushIn and lookupTag, so they are due in the same cycle as the inputs that select them, while every effect of an allocation, writeback, retirement or flush shows up one clock edge later. The bench drives inputs on the falling edge, compares all outputs against its own model one time unit later in the same cycle, and only then advances the model at the rising edge. Directed checks made right after an edge therefore see exactly the state that edge produced.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2,
    KIND_RSVD   = 2'd3
  } robKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic doAlloc;
    logic doCommit;
    logic doFlush;
  } robStrobes_t;

endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic             flushIn,
  input  logic             headDone,
  input  logic [1:0]       headKind,
  input  logic             headMisp,
  output logic             allocReady,
  output logic [TAG_W-1:0] tailPtr,
  output logic [TAG_W-1:0] headPtr,
  output logic             commitValid,
  output logic             flushOut,
  output logic [CNT_W-1:0] occupancy,
  output robStrobes_t      strb
);

  logic [CNT_W-1:0] count;

  function automatic logic [TAG_W-1:0] nextPtr(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    allocReady    = (count != CNT_W'(DEPTH));
    commitValid   = !flushIn && (count != '0) && headDone;
    flushOut      = flushIn ||
                    (commitValid && headKind == KIND_BRANCH && headMisp);
    strb.doFlush  = flushOut;
    strb.doAlloc  = allocValid && allocReady && !flushOut;
    strb.doCommit = commitValid && !flushOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.doFlush) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else begin
      if (strb.doAlloc)  tailPtr <= nextPtr(tailPtr);
      if (strb.doCommit) headPtr <= nextPtr(headPtr);
      count <= count + CNT_W'(strb.doAlloc) - CNT_W'(strb.doCommit);
    end
  end

  assign occupancy = count;

endmodule

// File: rtl/rob_data.sv
module rob_data
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  robStrobes_t       strb,
  input  logic [TAG_W-1:0]  tailPtr,
  input  logic [TAG_W-1:0]  headPtr,
  input  logic [1:0]        allocKind,
  input  logic [REG_W-1:0]  allocDest,
  input  logic              wbValid,
  input  logic [TAG_W-1:0]  wbTag,
  input  logic [DATA_W-1:0] wbValue,
  input  logic              wbMispredict,
  input  logic [TAG_W-1:0]  lookupTag,
  output logic              headDone,
  output logic [1:0]        headKind,
  output logic              headMisp,
  output logic [REG_W-1:0]  headDest,
  output logic [DATA_W-1:0] headValue,
  output logic              lookupReady,
  output logic [DATA_W-1:0] lookupValue
);

  logic [DEPTH-1:0]  entValid;
  logic [DEPTH-1:0]  entDone;
  logic [DEPTH-1:0]  entMisp;
  logic [1:0]        entKind  [DEPTH];
  logic [REG_W-1:0]  entDest  [DEPTH];
  logic [DATA_W-1:0] entValue [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : gEntry
    logic isAlloc, isCommit, isWb;
    assign isAlloc  = strb.doAlloc  && (tailPtr == TAG_W'(i));
    assign isCommit = strb.doCommit && (headPtr == TAG_W'(i));
    assign isWb     = wbValid && entValid[i] && (wbTag == TAG_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN || strb.doFlush) begin
        entValid[i] <= 1'b0;
        entDone[i]  <= 1'b0;
        entMisp[i]  <= 1'b0;
      end else begin
        if (isWb) begin
          entDone[i]  <= 1'b1;
          entMisp[i]  <= wbMispredict;
          entValue[i] <= wbValue;
        end
        if (isCommit) entValid[i] <= 1'b0;
        if (isAlloc) begin
          entValid[i] <= 1'b1;
          entDone[i]  <= 1'b0;
          entMisp[i]  <= 1'b0;
          entKind[i]  <= allocKind;
          entDest[i]  <= allocDest;
          entValue[i] <= '0;
        end
      end
    end
  end

  always_comb begin
    headDone    = entValid[headPtr] && entDone[headPtr];
    headKind    = entKind[headPtr];
    headMisp    = entMisp[headPtr];
    headDest    = entDest[headPtr];
    headValue   = entValue[headPtr];
    lookupReady = entValid[lookupTag] && entDone[lookupTag];
    lookupValue = entValue[lookupTag];
  end

endmodule

// File: rtl/rob_top.sv
module rob_top
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [1:0]        allocKind,
  input  logic [REG_W-1:0]  allocDest,
  output logic              allocReady,
  output logic [TAG_W-1:0]  allocTag,
  input  logic              wbValid,
  input  logic [TAG_W-1:0]  wbTag,
  input  logic [DATA_W-1:0] wbValue,
  input  logic              wbMispredict,
  input  logic              flushIn,
  input  logic [TAG_W-1:0]  lookupTag,
  output logic              lookupReady,
  output logic [DATA_W-1:0] lookupValue,
  output logic              commitValid,
  output logic [1:0]        commitKind,
  output logic [REG_W-1:0]  commitDest,
  output logic [DATA_W-1:0] commitValue,
  output logic              flushOut,
  output logic [CNT_W-1:0]  occupancy
);

  robStrobes_t      strb;
  logic [TAG_W-1:0] headPtr;
  logic             headDone, headMisp;

  rob_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .flushIn(flushIn),
    .headDone(headDone), .headKind(commitKind), .headMisp(headMisp),
    .allocReady(allocReady), .tailPtr(allocTag), .headPtr(headPtr),
    .commitValid(commitValid), .flushOut(flushOut),
    .occupancy(occupancy), .strb(strb)
  );

  rob_data #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .tailPtr(allocTag),
    .headPtr(headPtr), .allocKind(allocKind), .allocDest(allocDest),
    .wbValid(wbValid), .wbTag(wbTag), .wbValue(wbValue),
    .wbMispredict(wbMispredict), .lookupTag(lookupTag),
    .headDone(headDone), .headKind(commitKind), .headMisp(headMisp),
    .headDest(commitDest), .headValue(commitValue),
    .lookupReady(lookupReady), .lookupValue(lookupValue)
  );

endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             allocValid,
  input logic             allocReady,
  input logic [TAG_W-1:0] allocTag,
  input logic             flushIn,
  input logic             flushOut,
  input logic             commitValid,
  input logic [CNT_W-1:0] occupancy
);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= CNT_W'(DEPTH));

  a_r3_full_blocks: assert property (@(posedge clk) disable iff (!rstN)
    occupancy == CNT_W'(DEPTH) |-> !allocReady);

  a_r2_tag_advance: assert property (@(posedge clk) disable iff (!rstN)
    allocValid && allocReady && !flushOut |=>
      allocTag == (($past(allocTag) == TAG_W'(DEPTH - 1)) ? '0 : $past(allocTag) + 1'b1));

  a_r5_commit_needs_entry: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> occupancy != '0);

  a_r7_count_steady: assert property (@(posedge clk) disable iff (!rstN)
    allocValid && allocReady && commitValid && !flushOut |=>
      occupancy == $past(occupancy));

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |=> occupancy == '0 && allocTag == '0);

  a_r9_no_commit_on_flush: assert property (@(posedge clk) disable iff (!rstN)
    flushIn |-> !commitValid && flushOut);

endmodule

bind rob_top rob_checker #(.DEPTH(DEPTH)) checker_i (
  .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocReady(allocReady),
  .allocTag(allocTag), .flushIn(flushIn), .flushOut(flushOut),
  .commitValid(commitValid), .occupancy(occupancy)
);

// File: tb/rob_top_tb_top.sv
module rob_top_tb_top;

  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        allocValid = 0, wbValid = 0, wbMispredict = 0, flushIn = 0;
  logic [1:0]  allocKind = 0;
  logic [4:0]  allocDest = 0;
  logic [2:0]  wbTag = 0, lookupTag = 0;
  logic [31:0] wbValue = 0;
  logic        allocReady, lookupReady, commitValid, flushOut;
  logic [2:0]  allocTag;
  logic [31:0] lookupValue, commitValue;
  logic [1:0]  commitKind;
  logic [4:0]  commitDest;
  logic [3:0]  occupancy;

  int vecs = 0, errs = 0;
  bit done = 0;

  // bench model
  bit          mV[D], mD[D], mM[D];
  logic [1:0]  mK[D];
  logic [4:0]  mDst[D];
  logic [31:0] mVal[D];
  int          mHead = 0, mTail = 0, mCnt = 0;

  always #4 clk = ~clk;

  rob_top dut_i (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocKind(allocKind),
    .allocDest(allocDest), .allocReady(allocReady), .allocTag(allocTag),
    .wbValid(wbValid), .wbTag(wbTag), .wbValue(wbValue),
    .wbMispredict(wbMispredict), .flushIn(flushIn), .lookupTag(lookupTag),
    .lookupReady(lookupReady), .lookupValue(lookupValue),
    .commitValid(commitValid), .commitKind(commitKind),
    .commitDest(commitDest), .commitValue(commitValue),
    .flushOut(flushOut), .occupancy(occupancy)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit expCommit();
    return !flushIn && mCnt != 0 && mV[mHead] && mD[mHead];
  endfunction

  function automatic bit expFlush();
    return flushIn || (expCommit() && mK[mHead] == 2'd2 && mM[mHead]);
  endfunction

  function automatic int nxt(int p);
    return (p + 1) % D;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < D; i++) begin mV[i] = 0; mD[i] = 0; mM[i] = 0; end
    mHead = 0; mTail = 0; mCnt = 0;
  endtask

  // drive one cycle, compare, advance model
  task automatic step(bit aV, logic [1:0] aK, logic [4:0] aD, bit wV,
                      logic [2:0] wT, logic [31:0] wVal, bit wM, bit fI,
                      logic [2:0] lT);
    bit c, f, a;
    @(negedge clk);
    allocValid = aV; allocKind = aK; allocDest = aD; wbValid = wV;
    wbTag = wT; wbValue = wVal; wbMispredict = wM; flushIn = fI; lookupTag = lT;
    #1;
    c = expCommit(); f = expFlush(); a = aV && mCnt < D && !f;
    chk("R3", "allocReady", allocReady, mCnt < D);
    chk("R2", "allocTag", allocTag, mTail);
    chk("R7", "occupancy", occupancy, mCnt);
    chk("R5", "commitValid", commitValid, c);
    chk("R8", "flushOut", flushOut, f);
    if (c) begin
      chk("R6", "commitKind", commitKind, mK[mHead]);
      chk("R6", "commitDest", commitDest, mDst[mHead]);
      chk("R6", "commitValue", commitValue, mVal[mHead]);
    end
    chk("R4", "lookupReady", lookupReady, mV[lT] && mD[lT]);
    if (mV[lT] && mD[lT]) chk("R4", "lookupValue", lookupValue, mVal[lT]);
    @(posedge clk);
    if (f) model_clear();
    else begin
      if (wV && mV[wT]) begin mD[wT] = 1; mM[wT] = wM; mVal[wT] = wVal; end
      if (c) begin mV[mHead] = 0; mHead = nxt(mHead); end
      if (a) begin
        mV[mTail] = 1; mD[mTail] = 0; mM[mTail] = 0; mK[mTail] = aK;
        mDst[mTail] = aD; mVal[mTail] = 0; mTail = nxt(mTail);
      end
      mCnt = mCnt + int'(a) - int'(c);
    end
    #1;
  endtask

  task automatic idle(logic [2:0] lT);
    step(0, 0, 0, 0, 0, 0, 0, 0, lT);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errs++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed1234));
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1; #1;
    // R1 reset state
    chk("R1", "occupancy", occupancy, 0);
    chk("R1", "allocReady", allocReady, 1);
    chk("R1", "allocTag", allocTag, 0);
    chk("R1", "commitValid", commitValid, 0);
    chk("R1", "flushOut", flushOut, 0);

    // R2/R3: fill, then one more request blocked
    for (int i = 0; i < D; i++) step(1, 2'd0, 5'(i + 1), 0, 0, 0, 0, 0, 0);
    chk("R3", "occupancy full", occupancy, D);
    step(1, 2'd1, 5'd30, 0, 0, 0, 0, 0, 0);
    chk("R3", "occupancy after blocked alloc", occupancy, D);
    chk("R3", "allocTag after blocked alloc", allocTag, 0);
    // R5: younger completes first, no retirement
    step(0, 0, 0, 1, 3'd3, 32'hAAAA0003, 0, 0, 3);
    chk("R5", "commitValid younger done", commitValid, 0);
    chk("R4", "lookupReady tag3", lookupReady, 1);
    chk("R4", "lookupValue tag3", lookupValue, 32'hAAAA0003);
    // head completes, then retire with simultaneous alloc blocked? free one first
    step(0, 0, 0, 1, 3'd0, 32'hBEEF0000, 0, 0, 0);
    chk("R6", "commitValue head", commitValue, 32'hBEEF0000);
    chk("R6", "commitDest head", commitDest, 1);
    step(0, 0, 0, 1, 3'd1, 32'h11, 0, 0, 0);   // retires 0, completes 1
    chk("R6", "occupancy after retire", occupancy, D - 1);
    step(1, 2'd1, 5'd9, 0, 0, 0, 0, 0, 0);      // R7 alloc + retire of 1
    chk("R7", "occupancy alloc+retire", occupancy, D - 1);
    // R9 external flush
    step(0, 0, 0, 1, 3'd2, 32'h22, 0, 0, 0);
    step(1, 2'd0, 5'd4, 0, 0, 0, 0, 1, 0);
    chk("R9", "occupancy after flushIn", occupancy, 0);
    chk("R9", "allocTag after flushIn", allocTag, 0);
    // R10 writeback to free slot ignored
    step(0, 0, 0, 1, 3'd0, 32'hDEAD, 0, 0, 0);
    chk("R10", "lookupReady free slot", lookupReady, 0);
    step(1, 2'd0, 5'd7, 0, 0, 0, 0, 0, 0);
    chk("R10", "commitValid stale wb", commitValid, 0);
    chk("R10", "lookupReady stale wb", lookupReady, 0);
    // R11 correct branch then R8 mispredicted branch
    step(1, 2'd2, 5'd0, 1, 3'd0, 32'h77, 0, 0, 0);   // tag1 branch, tag0 done
    step(1, 2'd0, 5'd3, 1, 3'd1, 32'h1, 0, 0, 0);    // retire 0, branch ok
    idle(0);                                         // branch retires
    chk("R11", "flushOut correct branch", flushOut, 0);
    chk("R11", "occupancy keeps young", occupancy, 1);
    step(1, 2'd2, 5'd0, 1, 3'd2, 32'h5, 0, 0, 0);    // tag3 branch, tag2 done
    step(1, 2'd0, 5'd8, 1, 3'd3, 32'h6, 1, 0, 0);    // retire 2, branch misp
    step(1, 2'd0, 5'd9, 0, 0, 0, 0, 0, 0);           // branch retires -> flush
    chk("R8", "occupancy after mispredict", occupancy, 0);
    chk("R8", "allocTag after mispredict", allocTag, 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] t;
      bit wv;
      t = 3'($urandom % D);
      wv = ($urandom % 10) < 6;
      if (wv && ($urandom % 4) != 0) begin
        for (int k = 0; k < D; k++)
          if (mV[(mHead + k) % D] && !mD[(mHead + k) % D] && ($urandom % 2 == 0)) begin
            t = 3'((mHead + k) % D); break;
          end
      end
      step(($urandom % 10) < 6, 2'($urandom % 3), 5'($urandom), wv, t,
           $urandom, ($urandom % 4) == 0, ($urandom % 200) == 0,
           3'($urandom % D));
    end
    finish_run();
  end

endmodule